// File: doc/BRIEF.md
# Next-PC Instruction Fetch Unit

This unit owns the program counter of a single-cycle core and picks the address of the following instruction on every rising clock edge. The current instruction's decoded fields come back into the unit: a 16-bit immediate and a 26-bit jump target. The decoder also supplies a conditional-branch flag and a jump flag, and the ALU supplies its zero result. From these the unit selects one of three paths: the sequential path, a PC-relative branch scaled to words, or an absolute jump inside the current 256 MiB region.

The PC addresses a small word-organised instruction store held inside the unit. The store is read combinationally, so the 32-bit instruction for the current PC is available in the same cycle. The store is filled through a valid/ready write stream. That stream is ready only while the unit is held in reset. A beat transfers on a rising edge where both valid and ready are high. A beat offered while ready is low is dropped, and the offer does not need to be held. There is no back-pressure beyond that reset gate.

Top module: `fetch_pc_unit`

## Requirements
- R1: A rising edge with `rst` high sets `pc` to 0, whatever the other inputs are.
- R2: With `jmp_en` = 0 and `br_en` = 0, the next `pc` is `pc + 4`.
- R3: With `jmp_en` = 0, `br_en` = 1 and `zero` = 1, the next `pc` is `pc + 4 + (sign-extended imm16 << 2)`.
- R4: With `jmp_en` = 0, `br_en` = 1 and `zero` = 0, the next `pc` is `pc + 4`.
- R5: When `br_en` = 0, the value of `zero` has no effect on the next `pc`.
- R6: With `jmp_en` = 1, the next `pc` is built from three parts, from most to least significant: bits 31:28 of `pc + 4`, then `jtarget[25:0]`, then `2'b00`.
- R7: When `jmp_en` and `br_en` are both 1, the jump of R6 wins, even when `zero` = 1.
- R8: `pc[1:0]` is always `2'b00`.
- R9: `instr` is, in the same cycle, the stored word whose index is `pc[IDX_W+1:2]`. The higher PC bits are ignored, so the index wraps modulo the store depth.
- R10: `ld_ready` equals `rst`. A beat with `ld_valid` and `ld_ready` both high writes `ld_word` to index `ld_idx`. A beat with `ld_valid` high while `ld_ready` is low leaves the store unchanged.
- R11: PC arithmetic wraps modulo 2^32. A branch below address 0 lands at the top of the address space, and `pc + 4` from 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the load stream |
| br_en | input | 1 | Conditional-branch flag from the decoder |
| jmp_en | input | 1 | Absolute-jump flag from the decoder |
| zero | input | 1 | ALU zero result |
| imm16 | input | 16 | Branch offset in words, two's complement |
| jtarget | input | 26 | Jump target word field |
| ld_valid | input | 1 | Load stream beat valid |
| ld_ready | output | 1 | Load stream ready (high during reset) |
| ld_idx | input | IDX_W | Load stream word index |
| ld_word | input | 32 | Load stream data word |
| pc | output | 32 | Current program counter |
| instr | output | 32 | Instruction word at `pc` |

## Verification
The properties assume that `br_en`, `jmp_en`, `zero`, `imm16` and `jtarget` hold defined values at every rising edge outside reset. They also assume that reset is held from time zero. The bench changes inputs only at falling edges, always to known values, and asserts reset before the first edge. It fills every store entry while reset is held, so the combinational read never returns an unwritten word. The bench offers one load beat outside reset, only to show that it is dropped.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int WORD_W   = 32;
  localparam int IMM_W    = 16;
  localparam int TGT_W    = 26;
  localparam int ALIGN_W  = 2;

  typedef enum logic [1:0] {
    NXT_SEQ  = 2'd0,
    NXT_BR   = 2'd1,
    NXT_JUMP = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] pc_q
);
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  // R8: the stored PC always stays word aligned
  a_r8_word_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
endmodule

// File: rtl/fetch_next_pc.sv
module fetch_next_pc
  import fetch_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             [AW-1:0] pc,
  input  logic                      br_en,
  input  logic                      jmp_en,
  input  logic                      zero,
  input  logic          [IMM_W-1:0] imm16,
  input  logic          [TGT_W-1:0] jtarget,
  output logic             [AW-1:0] pc_nxt
);
  localparam int EXT_W = AW - IMM_W - ALIGN_W;
  localparam int HI_W  = AW - TGT_W - ALIGN_W;

  logic [AW-1:0] seq_pc;
  logic [AW-1:0] br_off;
  logic [AW-1:0] br_pc;
  logic [AW-1:0] jmp_pc;
  nxt_sel_e      sel;

  assign seq_pc = pc + {{(AW-3){1'b0}}, 3'd4};
  assign br_off = {{EXT_W{imm16[IMM_W-1]}}, imm16, {ALIGN_W{1'b0}}};
  assign br_pc  = seq_pc + br_off;
  assign jmp_pc = {seq_pc[AW-1 -: HI_W], jtarget, {ALIGN_W{1'b0}}};

  // jump has priority; the branch path needs both the flag and zero
  always_comb begin
    if (jmp_en)              sel = NXT_JUMP;
    else if (br_en && zero)  sel = NXT_BR;
    else                     sel = NXT_SEQ;
  end

  always_comb begin
    unique case (sel)
      NXT_JUMP: pc_nxt = jmp_pc;
      NXT_BR:   pc_nxt = br_pc;
      default:  pc_nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/fetch_imem.sv
module fetch_imem #(
  parameter int IDX_W = 6,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic    [DW-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic    [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
  import fetch_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 br_en,
  input  logic                 jmp_en,
  input  logic                 zero,
  input  logic     [IMM_W-1:0] imm16,
  input  logic     [TGT_W-1:0] jtarget,
  input  logic                 ld_valid,
  output logic                 ld_ready,
  input  logic     [IDX_W-1:0] ld_idx,
  input  logic    [WORD_W-1:0] ld_word,
  output logic    [WORD_W-1:0] pc,
  output logic    [WORD_W-1:0] instr
);
  localparam int AW    = WORD_W;
  localparam int EXT_W = AW - IMM_W - ALIGN_W;
  localparam int HI_W  = AW - TGT_W - ALIGN_W;

  logic [AW-1:0] pc_nxt;
  logic          ld_fire;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid && ld_ready;

  fetch_next_pc #(.AW(AW)) u_nxt (
    .pc      (pc),
    .br_en   (br_en),
    .jmp_en  (jmp_en),
    .zero    (zero),
    .imm16   (imm16),
    .jtarget (jtarget),
    .pc_nxt  (pc_nxt)
  );

  fetch_pc_reg #(.AW(AW)) u_pc (
    .clk    (clk),
    .rst    (rst),
    .pc_nxt (pc_nxt),
    .pc_q   (pc)
  );

  fetch_imem #(.IDX_W(IDX_W), .DW(WORD_W)) u_mem (
    .clk     (clk),
    .wr_en   (ld_fire),
    .wr_idx  (ld_idx),
    .wr_data (ld_word),
    .rd_idx  (pc[IDX_W+1:ALIGN_W]),
    .rd_data (instr)
  );

  // R2 and R5: without branch or jump the PC steps by one word, zero ignored
  a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && !br_en) |=> (pc == $past(pc) + 32'd4));

  // R3: taken branch adds the word-scaled offset to the sequential address
  a_r3_branch_taken: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && br_en && zero) |=>
      (pc == $past(pc) + 32'd4 +
             {{EXT_W{$past(imm16[IMM_W-1])}}, $past(imm16), 2'b00}));

  // R4: branch flag with zero low falls through
  a_r4_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
    (!jmp_en && br_en && !zero) |=> (pc == $past(pc) + 32'd4));

  // R6 and R7: a jump fixes the low bits from the target whatever the branch inputs
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> (pc[AW-HI_W-1:0] == {$past(jtarget), 2'b00}));

  // R6: the region bits come from the incremented PC
  a_r6_jump_region: assert property (@(posedge clk) disable iff (rst)
    jmp_en |=> ((pc >> (AW-HI_W)) == (($past(pc) + 32'd4) >> (AW-HI_W))));
endmodule

// File: tb/fetch_pc_unit_tb.sv
module fetch_pc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 6;
  localparam int DEPTH      = 1 << IDX_W;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_en = 1'b0, jmp_en = 1'b0, zero = 1'b0;
  logic [15:0] imm16 = '0;
  logic [25:0] jtarget = '0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [IDX_W-1:0] ld_idx = '0;
  logic [31:0] ld_word = '0;
  logic [31:0] pc, instr;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [31:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_pc_unit #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst(rst), .br_en(br_en), .jmp_en(jmp_en), .zero(zero),
    .imm16(imm16), .jtarget(jtarget), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_idx(ld_idx), .ld_word(ld_word), .pc(pc), .instr(instr)
  );

  function automatic logic [31:0] word_of(int i);
    return (32'(i) * 32'h9E3779B9) ^ 32'h0F1E2D3C;
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] p, logic b, logic j,
                                             logic z, logic [15:0] im, logic [25:0] t);
    logic [31:0] s;
    s = p + 32'd4;
    if (j)          return {s[31:28], t, 2'b00};
    else if (b && z) return s + ({{16{im[15]}}, im} << 2);
    else            return s;
  endfunction

  function automatic logic [15:0] imm_pick(int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      3: return 16'h7FFF;
      4: return 16'h8000;
      default: return 16'h0005;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic b, logic j, logic z,
                      logic [15:0] im, logic [25:0] t);
    logic [31:0] nxt;
    br_en = b; jmp_en = j; zero = z; imm16 = im; jtarget = t;
    nxt = model_next(exp_pc, b, j, z, im, t);
    @(posedge clk);
    @(negedge clk);
    chk(req, pc, nxt);
    chk("R9", instr, word_of(int'(nxt[IDX_W+1:2])));
    chk("R8", {30'd0, pc[1:0]}, 32'd0);
    exp_pc = nxt;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset pc", pc, 32'd0);
    chk("R10 ready in reset", {31'd0, ld_ready}, 32'd1);

    for (int i = 0; i < DEPTH; i++) begin
      ld_valid = 1'b1; ld_idx = IDX_W'(i); ld_word = word_of(i);
      @(negedge clk);
    end
    ld_valid = 1'b0;

    rst = 1'b0;
    #1;
    chk("R10 ready out of reset", {31'd0, ld_ready}, 32'd0);
    chk("R9 first word", instr, word_of(0));
    exp_pc = 32'd0;

    // R10: a beat outside reset must be dropped
    ld_valid = 1'b1; ld_idx = IDX_W'(3); ld_word = ~word_of(3);
    step("R2", 1'b0, 1'b0, 1'b0, 16'h0000, 26'd0);
    ld_valid = 1'b0;
    step("R5 zero ignored", 1'b0, 1'b0, 1'b1, 16'hFFFF, 26'd0);
    step("R5 zero ignored", 1'b0, 1'b0, 1'b1, 16'h0040, 26'd9);
    step("R6", 1'b0, 1'b1, 1'b0, 16'h0000, 26'd3);
    chk("R10 dropped beat", instr, word_of(3));

    for (int j = 0; j < 2; j++)
      for (int b = 0; b < 2; b++)
        for (int z = 0; z < 2; z++)
          for (int k = 0; k < 6; k++) begin
            string r;
            if (j == 1)      r = (b == 1 && z == 1) ? "R7" : "R6";
            else if (b == 1) r = (z == 1) ? "R3" : "R4";
            else             r = (z == 1) ? "R5" : "R2";
            step(r, b[0], j[0], z[0], imm_pick(k),
                 26'(32'(k) * 32'h00AAAAA5 + 32'(b * 4 + z)));
          end

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid-run reset", pc, 32'd0);
    rst = 1'b0;
    exp_pc = 32'd0;

    step("R11 branch below zero", 1'b1, 1'b0, 1'b1, 16'hFFFE, 26'd0);
    chk("R11 top address", pc, 32'hFFFF_FFFC);
    step("R11 increment wraps", 1'b0, 1'b0, 1'b0, 16'h0000, 26'd0);
    chk("R11 back to zero", pc, 32'd0);
    step("R11 branch below zero", 1'b1, 1'b0, 1'b1, 16'hFFFD, 26'd0);
    step("R6 region kept", 1'b1, 1'b1, 1'b1, 16'h1234, 26'h0000155);
    chk("R6 region bits", pc, 32'hF000_0554);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule